// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a memory-mapped watchdog. While it is enabled, it counts a slow tick that is supplied from outside. If software lets the count reach a programmed limit without servicing the timer, the block raises a reset request. The reset request stays set until a system reset.

Software reaches three registers over a simple register bus: a control word, a command/count word and a limit word. A service operation and a reconfiguration are not ordinary writes. Each is recognised only when an exact key is written to the command address. In wide command mode the key arrives as one 32-bit word. In narrow mode it arrives as two 16-bit halves in a fixed order, low half first. A reconfiguration key opens a short window, and the window accepts exactly one write to the control or limit word. The count runs at 1 kHz, so a limit of N seconds is N×1000 ticks, and the intended range is 1 to 128 seconds.

If software writes the control word with the update-permit bit clear, the configuration is sealed. From then on, reconfiguration keys are ignored until reset.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the control word reads 0x0000_0020, with only the update-permit bit (bit 5) set. The count reads 0, the limit reads TOV_RST (default 1000), and `wdt_rst_req` is low.
- R2: A read returns the control word at offset 0x0, the current count at offset 0x4 and the limit at offset 0x8. Any other offset reads 0.
- R3: In wide mode (control bit 13 = 1), writing 0xB480A602 to offset 0x4 clears the count to 0. Any other value leaves the count unchanged.
- R4: In narrow mode (bit 13 = 0), a service happens only when 0xA602 and then 0xB480 are written to offset 0x4 (bits 15:0). A mismatching second half discards the pair. A lone 0xB480 does nothing.
- R5: The reconfiguration key is 0xD928C520 as one wide write, or 0xC520 then 0xD928 in narrow mode. After the key, control bit 11 reads 1.
- R6: Writes to offsets 0x0 or 0x8 while bit 11 is 0 have no effect.
- R7: The first write to offset 0x0 or 0x8 inside a window takes effect and closes the window, so bit 11 reads 0 afterwards.
- R8: A window left unused closes by itself after WIN_CYC bus clocks (default 16). Later configuration writes are then ignored.
- R9: The count advances by one per tick only while control bit 7 is 1. While bit 7 is 0 the count holds.
- R10: On the tick that brings the count to the limit, `wdt_rst_req` rises and counting stops. A later service clears the count but leaves the request high.
- R11: A service while the block is disabled clears the count and changes nothing else.
- R12: A control write inside a window sets bit 10 (reconfiguration complete). If that write had bit 5 clear, every later reconfiguration key is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| tick | input | 1 | One-cycle pulse per slow time base tick |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational, zero when not reading) |
| wdt_rst_req | output | 1 | Sticky reset request |

## Verification
Service keys are tried in several forms, and each form separates a different fault:
- Exact wide keys and near-miss wide words (one bit off) separate exact compare from partial decoding.
- Narrow pairs in the right order, a broken pair followed by a lone second half, and a complete pair separate a true two-step sequence from single-half matching.
- Configuration writes are sent with the window closed, inside an open window, twice in one window, and after the window has timed out. These cases separate each rule that closes the window.
- Counting is driven enabled, disabled and past the limit, to tell a free-running count from a gated one and to show whether the reset request is sticky.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;

    // Register offsets (byte addresses on the register bus)
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CMD  = 4'h4;
    localparam logic [3:0] OFS_LIM  = 4'h8;

    // Control word bit positions
    localparam int B_WIDE   = 13;
    localparam int B_OPEN   = 11;
    localparam int B_DONE   = 10;
    localparam int B_RUN    = 7;
    localparam int B_PERMIT = 5;

    // Command keys
    localparam logic [31:0] KEY_SERVICE = 32'hB480_A602;
    localparam logic [31:0] KEY_RECONF  = 32'hD928_C520;
    localparam logic [15:0] SVC_FIRST   = KEY_SERVICE[15:0];
    localparam logic [15:0] SVC_SECOND  = KEY_SERVICE[31:16];
    localparam logic [15:0] RCF_FIRST   = KEY_RECONF[15:0];
    localparam logic [15:0] RCF_SECOND  = KEY_RECONF[31:16];

    typedef enum logic [1:0] {
        PAIR_IDLE = 2'd0,
        PAIR_SVC  = 2'd1,
        PAIR_RCF  = 2'd2
    } pair_e;

endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect
    import keyed_wdt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wide_mode,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_data,
    output logic        service_hit,
    output logic        reconf_hit
);

    typedef struct packed {
        pair_e pair;
    } kd_state_t;

    kd_state_t st_d, st_q;
    logic [15:0] half;

    assign half = cmd_data[15:0];

    always_comb begin
        st_d        = st_q;
        service_hit = 1'b0;
        reconf_hit  = 1'b0;
        if (wide_mode) begin
            st_d.pair = PAIR_IDLE;
            if (cmd_wr) begin
                service_hit = (cmd_data == KEY_SERVICE);
                reconf_hit  = (cmd_data == KEY_RECONF);
            end
        end else if (cmd_wr) begin
            case (st_q.pair)
                PAIR_IDLE: begin
                    if (half == SVC_FIRST)      st_d.pair = PAIR_SVC;
                    else if (half == RCF_FIRST) st_d.pair = PAIR_RCF;
                end
                PAIR_SVC: begin
                    service_hit = (half == SVC_SECOND);
                    st_d.pair   = PAIR_IDLE;
                end
                PAIR_RCF: begin
                    reconf_hit = (half == RCF_SECOND);
                    st_d.pair  = PAIR_IDLE;
                end
                default: st_d.pair = PAIR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pair: PAIR_IDLE};
        else        st_q <= st_d;
    end

    // R4: a pair never produces both key kinds at once
    p_onehot_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({service_hit, reconf_hit}));

    // R4: in narrow mode a service needs a pending first half
    p_pair_needs_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_mode && service_hit) |-> (st_q.pair == PAIR_SVC));

endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int WIN_CYC = 16,
    parameter int TOV_RST = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reconf_hit,
    input  logic             ctrl_wr,
    input  logic             lim_wr,
    input  logic [31:0]      wdata,
    output logic             wide_mode,
    output logic             run,
    output logic             permit,
    output logic             done,
    output logic             win_open,
    output logic [CNT_W-1:0] limit
);

    localparam int WIN_W = $clog2(WIN_CYC + 1);

    typedef struct packed {
        logic             wide;
        logic             run;
        logic             permit;
        logic             done;
        logic             open;
        logic [WIN_W-1:0] win;
        logic [CNT_W-1:0] lim;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic sealed;
    logic cfg_take;

    always_comb begin
        st_d     = st_q;
        sealed   = st_q.done && !st_q.permit;
        cfg_take = (ctrl_wr || lim_wr) && st_q.open;

        if (st_q.open) begin
            if (cfg_take || st_q.win == '0) st_d.open = 1'b0;
            else                             st_d.win  = st_q.win - 1'b1;
        end
        if (ctrl_wr && st_q.open) begin
            st_d.wide   = wdata[B_WIDE];
            st_d.run    = wdata[B_RUN];
            st_d.permit = wdata[B_PERMIT];
            st_d.done   = 1'b1;
        end
        if (lim_wr && st_q.open) st_d.lim = wdata[CNT_W-1:0];
        if (reconf_hit && !sealed) begin
            st_d.open = 1'b1;
            st_d.win  = WIN_W'(WIN_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.permit <= 1'b1;
            st_q.lim    <= CNT_W'(TOV_RST);
        end else begin
            st_q <= st_d;
        end
    end

    assign wide_mode = st_q.wide;
    assign run       = st_q.run;
    assign permit    = st_q.permit;
    assign done      = st_q.done;
    assign win_open  = st_q.open;
    assign limit     = st_q.lim;

    // R6: a limit write with no open window leaves the limit alone
    p_locked_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_wr && !win_open) |=> $stable(limit));

    // R6: a control write with no open window leaves the run bit alone
    p_locked_ctrl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !win_open) |=> $stable(run));

    // R7: an accepted configuration write closes the window
    p_win_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_wr || lim_wr) && win_open) |=> !win_open);

    // R12: once sealed, the window stays shut
    p_sealed_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !permit) |=> !win_open);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             service,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             rst_req
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (service) begin
            st_d.cnt = '0;
        end else if (run && tick && !st_q.req) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_d.cnt >= limit) st_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign rst_req = st_q.req;

    // R3: a service leaves the count at zero
    p_service_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> (count == '0));

    // R9: with counting disabled the count holds unless serviced
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !service) |=> $stable(count));

    // R10: the reset request never drops before reset
    p_sticky_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    // R10: the request can only rise on an enabled tick
    p_req_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> $past(run && tick));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import keyed_wdt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int WIN_CYC = 16,
    parameter int TOV_RST = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_req
);

    logic             cmd_wr, ctrl_wr, lim_wr;
    logic             service_hit, reconf_hit;
    logic             wide_mode, run, permit, done, win_open;
    logic [CNT_W-1:0] limit, count;
    logic [31:0]      ctrl_word;

    assign cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
    assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
    assign lim_wr  = bus_wr && (bus_addr == OFS_LIM);

    wdt_key_detect u_keys (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .cmd_wr     (cmd_wr),
        .cmd_data   (bus_wdata),
        .service_hit(service_hit),
        .reconf_hit (reconf_hit)
    );

    wdt_cfg_regs #(
        .CNT_W  (CNT_W),
        .WIN_CYC(WIN_CYC),
        .TOV_RST(TOV_RST)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reconf_hit(reconf_hit),
        .ctrl_wr   (ctrl_wr),
        .lim_wr    (lim_wr),
        .wdata     (bus_wdata),
        .wide_mode (wide_mode),
        .run       (run),
        .permit    (permit),
        .done      (done),
        .win_open  (win_open),
        .limit     (limit)
    );

    wdt_counter #(
        .CNT_W(CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run),
        .service(service_hit),
        .limit  (limit),
        .count  (count),
        .rst_req(wdt_rst_req)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[B_WIDE]   = wide_mode;
        ctrl_word[B_OPEN]   = win_open;
        ctrl_word[B_DONE]   = done;
        ctrl_word[B_RUN]    = run;
        ctrl_word[B_PERMIT] = permit;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_word;
                OFS_CMD:  bus_rdata = 32'(count);
                OFS_LIM:  bus_rdata = 32'(limit);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2: reads at unmapped offsets return zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr != OFS_CTRL && bus_addr != OFS_CMD && bus_addr != OFS_LIM)
        |-> (bus_rdata == '0));

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 47;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 4'h0, 32'h0,         32'h20,   4'd1 },  // R1 ctrl reset
        '{OP_RD, 4'h4, 32'h0,         32'h0,    4'd1 },  // R1 count reset
        '{OP_RD, 4'h8, 32'h0,         32'd1000, 4'd1 },  // R1 limit reset
        '{OP_WR, 4'h8, 32'd5,         32'h0,    4'd6 },  // R6 locked write
        '{OP_RD, 4'h8, 32'h0,         32'd1000, 4'd6 },  // R6
        '{OP_WR, 4'h4, 32'hC520,      32'h0,    4'd5 },  // R5 narrow key low
        '{OP_WR, 4'h4, 32'hD928,      32'h0,    4'd5 },  // R5 narrow key high
        '{OP_RD, 4'h0, 32'h0,         32'h820,  4'd5 },  // R5 open flag
        '{OP_WR, 4'h8, 32'd100,       32'h0,    4'd7 },  // R7 accepted write
        '{OP_RD, 4'h0, 32'h0,         32'h20,   4'd7 },  // R7 window closed
        '{OP_RD, 4'h8, 32'h0,         32'd100,  4'd2 },  // R2 limit readback
        '{OP_WR, 4'h0, 32'h80,        32'h0,    4'd6 },  // R6 locked ctrl
        '{OP_RD, 4'h0, 32'h0,         32'h20,   4'd6 },  // R6
        '{OP_WR, 4'h4, 32'hC520,      32'h0,    4'd5 },
        '{OP_WR, 4'h4, 32'hD928,      32'h0,    4'd5 },
        '{OP_WR, 4'h0, 32'h20A0,      32'h0,    4'd12},  // R12 wide, run, permit
        '{OP_RD, 4'h0, 32'h0,         32'h24A0, 4'd12},  // R12 done flag
        '{OP_TK, 4'h0, 32'd3,         32'h0,    4'd9 },  // R9
        '{OP_RD, 4'h4, 32'h0,         32'd3,    4'd9 },  // R9 count
        '{OP_WR, 4'h4, 32'hB480A603,  32'h0,    4'd3 },  // R3 near miss
        '{OP_RD, 4'h4, 32'h0,         32'd3,    4'd3 },  // R3
        '{OP_WR, 4'h4, 32'hB480A602,  32'h0,    4'd3 },  // R3 wide service
        '{OP_RD, 4'h4, 32'h0,         32'd0,    4'd3 },  // R3
        '{OP_TK, 4'h0, 32'd2,         32'h0,    4'd9 },
        '{OP_RD, 4'h4, 32'h0,         32'd2,    4'd9 },  // R9
        '{OP_WR, 4'h4, 32'hD928C520,  32'h0,    4'd5 },  // R5 wide key
        '{OP_RD, 4'h0, 32'h0,         32'h2CA0, 4'd5 },  // R5
        '{OP_WR, 4'h0, 32'h00A0,      32'h0,    4'd12},  // R12 back to narrow
        '{OP_RD, 4'h0, 32'h0,         32'h4A0,  4'd12},  // R12
        '{OP_WR, 4'h4, 32'hA602,      32'h0,    4'd4 },  // R4 first half
        '{OP_WR, 4'h4, 32'h1234,      32'h0,    4'd4 },  // R4 broken pair
        '{OP_WR, 4'h4, 32'hB480,      32'h0,    4'd4 },  // R4 lone second half
        '{OP_RD, 4'h4, 32'h0,         32'd2,    4'd4 },  // R4 no service
        '{OP_WR, 4'h4, 32'hA602,      32'h0,    4'd4 },
        '{OP_WR, 4'h4, 32'hB480,      32'h0,    4'd4 },
        '{OP_RD, 4'h4, 32'h0,         32'd0,    4'd4 },  // R4 serviced
        '{OP_TK, 4'h0, 32'd2,         32'h0,    4'd9 },
        '{OP_RD, 4'h4, 32'h0,         32'd2,    4'd9 },
        '{OP_WR, 4'h4, 32'hC520,      32'h0,    4'd11},
        '{OP_WR, 4'h4, 32'hD928,      32'h0,    4'd11},
        '{OP_WR, 4'h0, 32'h20,        32'h0,    4'd11},  // R11 disable
        '{OP_TK, 4'h0, 32'd3,         32'h0,    4'd9 },
        '{OP_RD, 4'h4, 32'h0,         32'd2,    4'd9 },  // R9 held while off
        '{OP_WR, 4'h4, 32'hA602,      32'h0,    4'd11},
        '{OP_WR, 4'h4, 32'hB480,      32'h0,    4'd11},
        '{OP_RD, 4'h4, 32'h0,         32'd0,    4'd11},  // R11 cleared
        '{OP_RD, 4'h0, 32'h0,         32'h420,  4'd11}   // R11 ctrl unchanged
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt u_keyed_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wdt_rst_req(wdt_rst_req)
    );

    task automatic check(input int tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, input logic [31:0] exp, input int tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic chk_req(input logic exp);
        @(negedge clk);
        #1;
        check(10, {31'b0, wdt_rst_req}, {31'b0, exp});
    endtask

    task automatic narrow_reconf();
        do_wr(4'h4, 32'hC520);
        do_wr(4'h4, 32'hD928);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk_req(1'b0);  // R1 request low after reset

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_RD:   do_rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                OP_WR:   do_wr(VEC[i].addr, VEC[i].data);
                default: do_ticks(int'(VEC[i].data));
            endcase
        end
        do_rd(4'hC, 32'h0, 2);  // R2 unmapped offset

        // R10: limit reached raises a sticky request
        narrow_reconf();
        do_wr(4'h8, 32'd4);
        narrow_reconf();
        do_wr(4'h0, 32'hA0);
        do_ticks(3);
        do_rd(4'h4, 32'd3, 10);
        chk_req(1'b0);
        do_ticks(1);
        chk_req(1'b1);
        do_rd(4'h4, 32'd4, 10);
        do_ticks(3);
        do_rd(4'h4, 32'd4, 10);   // R10 counting stopped
        do_wr(4'h4, 32'hA602);
        do_wr(4'h4, 32'hB480);
        do_rd(4'h4, 32'd0, 10);
        chk_req(1'b1);            // R10 still high after service

        // R8: window expires unused
        narrow_reconf();
        do_rd(4'h0, 32'hCA0, 8);
        repeat (20) @(negedge clk);
        do_rd(4'h0, 32'h4A0, 8);
        do_wr(4'h8, 32'd9);
        do_rd(4'h8, 32'd4, 8);

        // R12: sealing with permit clear
        narrow_reconf();
        do_wr(4'h0, 32'h80);
        do_rd(4'h0, 32'h480, 12);
        narrow_reconf();
        do_rd(4'h0, 32'h480, 12);
        do_wr(4'h8, 32'd7);
        do_rd(4'h8, 32'd4, 12);

        // R1: reset recovers everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_req(1'b0);
        do_rd(4'h0, 32'h20, 1);
        do_rd(4'h4, 32'h0, 1);
        do_rd(4'h8, 32'd1000, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R0 actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule